// File: doc/BRIEF.md
# Method Router with Subchannel Engine Binding

This block takes commands, each made of a method offset, a subchannel number and a 32-bit parameter. It holds them in a small internal queue and dispatches them one at a time. Method 0 binds a subchannel. Its parameter is an object handle. The block sends the handle out on a lookup port, waits for the answer, and stores the 2-bit engine code it gets back in that subchannel's slot. It also records the same code as the most recently bound engine. A method at or above 0x100 goes out on the engine port, tagged with the code currently bound to its subchannel. Any other method leaves the queue and has no effect.

Software reaches three words through a small register port. The first holds the pull enable, which starts and stops draining. The second is the packed binding table. The third reports queue status. The engines themselves and the handle lookup logic lie outside the block.

Top module: `method_router`

## Requirements
- R1: An entry leaves the queue only while the queue holds an entry and the pull enable (bit 0 at address 0, 0 after reset) is 1. With the enable at 0, queued entries stay put. Writing 1 again resumes draining in arrival order.
- R2: A method-0 entry presents its parameter on `lk_handle` with `lk_valid` held until `lk_ready`. No later entry is dispatched until `lk_resp_valid` returns.
- R3: The engine code on `lk_resp_valid` is written into the 2-bit slot of the entry's subchannel. It also becomes the last-bound engine. A response overrides a software write to that slot in the same cycle.
- R4: An entry with method >= 0x100 appears on the engine port with its method, subchannel and parameter. `eng_code` carries the slot bound to that subchannel when the entry is taken from the queue.
- R5: While `eng_valid` is 1 and `eng_ready` is 0, the engine port stays valid and all its fields stay unchanged.
- R6: Methods 0x001 to 0x0FF are removed from the queue and produce nothing on the engine port or the lookup port.
- R7: Address 1 holds the binding table, with subchannel i in bits 2i+1:2i. A write loads all eight slots. A read returns the packed value.
- R8: Address 2 reads bit 0 = 1 exactly when the queue is empty, and bits 9:8 = the last-bound engine. All other bits read 0.
- R9: `cmd_full` is 1 when DEPTH entries are queued. A push while full is dropped.
- R10: After reset the queue is empty, the bindings and the last engine are 0, pulling is off, and `lk_valid` and `eng_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push a command into the queue |
| cmd_method | input | MW | Method offset of the pushed command |
| cmd_subch | input | SW | Subchannel of the pushed command |
| cmd_param | input | DW | Parameter of the pushed command |
| cmd_full | output | 1 | Queue is full |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 bindings, 2 status) |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| lk_valid | output | 1 | Lookup request valid |
| lk_ready | input | 1 | Lookup request accepted |
| lk_handle | output | DW | Object handle to look up |
| lk_resp_valid | input | 1 | Lookup answer valid |
| lk_resp_engine | input | EW | Engine code owning the handle |
| eng_valid | output | 1 | Forwarded method valid |
| eng_ready | input | 1 | Engine accepts the method |
| eng_code | output | EW | Engine bound to the subchannel |
| eng_subch | output | SW | Subchannel of the method |
| eng_method | output | MW | Method offset |
| eng_param | output | DW | Method parameter |

## Verification
A random stream mixes bind commands, ignored low methods and forwarded methods. The lookup answers depend on the handle, so each later forward shows whether the binding that came before it landed in the correct slot. Directed runs cover the following cases:
- A forward on every subchannel under a known packed value, which checks the slot bit positions.
- Pushes with pulling off, which checks that the queue stalls and then resumes in order.
- Overfilling the queue, which checks that surplus pushes are dropped.
- A long engine stall, which checks that the engine port holds its fields.

Random engine backpressure and random lookup delays, together with pull toggling in the middle of the stream, check that no entry is lost, duplicated or reordered.

// File: rtl/method_router.sv
module method_router #(
  parameter int DEPTH = 8,
  parameter int MW = 16,
  parameter int NSUB = 8,
  parameter int EW = 2,
  parameter int DW = 32,
  parameter int FWD_BASE = 'h100,
  localparam int SW = $clog2(NSUB),
  localparam int AW = $clog2(DEPTH),
  localparam int RW = (NSUB * EW > 16) ? NSUB * EW : 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_push,
  input  logic [MW-1:0] cmd_method,
  input  logic [SW-1:0] cmd_subch,
  input  logic [DW-1:0] cmd_param,
  output logic          cmd_full,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          lk_valid,
  input  logic          lk_ready,
  output logic [DW-1:0] lk_handle,
  input  logic          lk_resp_valid,
  input  logic [EW-1:0] lk_resp_engine,
  output logic          eng_valid,
  input  logic          eng_ready,
  output logic [EW-1:0] eng_code,
  output logic [SW-1:0] eng_subch,
  output logic [MW-1:0] eng_method,
  output logic [DW-1:0] eng_param
);
  localparam int ENT = MW + SW + DW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);
  localparam logic [1:0] A_CTRL = 2'd0, A_BIND = 2'd1, A_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_LREQ, S_LWAIT, S_FWD} state_t;
  state_t state;

  logic [ENT-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic pull_q;
  logic [NSUB*EW-1:0] bind_q;
  logic [EW-1:0] last_q;
  logic [SW-1:0] sub_q;

  logic [MW-1:0] hm;
  logic [SW-1:0] hs;
  logic [DW-1:0] hp;
  logic empty, push, pop, is_bind, is_fwd;

  assign {hm, hs, hp} = mem[rp];
  assign empty = (cnt == '0);
  assign cmd_full = (cnt == FULLCNT);
  assign push = cmd_push && !cmd_full;
  assign pop = (state == S_IDLE) && pull_q && !empty;
  assign is_bind = (hm == '0);
  assign is_fwd = (32'(hm) >= FWD_BASE);
  assign lk_valid = (state == S_LREQ);
  assign eng_valid = (state == S_FWD);

  logic unused_bits;
  assign unused_bits = ^reg_wdata[RW-1:1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[0] = pull_q;
      A_BIND: reg_rdata[NSUB*EW-1:0] = bind_q;
      A_STAT: begin
        reg_rdata[0] = empty;
        reg_rdata[8 +: EW] = last_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {cmd_method, cmd_subch, cmd_param};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      pull_q <= 1'b0;
      bind_q <= '0;
      last_q <= '0;
      sub_q <= '0;
      lk_handle <= '0;
      eng_code <= '0;
      eng_subch <= '0;
      eng_method <= '0;
      eng_param <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) pull_q <= reg_wdata[0];
      if (reg_wr && reg_addr == A_BIND) bind_q <= reg_wdata[NSUB*EW-1:0];
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
      case (state)
        S_IDLE:
          if (pop) begin
            if (is_bind) begin
              lk_handle <= hp;
              sub_q <= hs;
              state <= S_LREQ;
            end else if (is_fwd) begin
              eng_code <= bind_q[hs*EW +: EW];
              eng_subch <= hs;
              eng_method <= hm;
              eng_param <= hp;
              state <= S_FWD;
            end
          end
        S_LREQ: if (lk_ready) state <= S_LWAIT;
        S_LWAIT:
          if (lk_resp_valid) begin
            bind_q[sub_q*EW +: EW] <= lk_resp_engine;
            last_q <= lk_resp_engine;
            state <= S_IDLE;
          end
        S_FWD: if (eng_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLCNT);
  p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_q |=> cnt >= $past(cnt));
  p_lk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_ready |=> lk_valid && $stable(lk_handle));
  p_lk_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> cnt >= $past(cnt));
  p_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LWAIT && lk_resp_valid |=> last_q == $past(lk_resp_engine));
  p_fwd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> 32'(eng_method) >= FWD_BASE);
  p_eng_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid &&
      $stable({eng_code, eng_subch, eng_method, eng_param}));
endmodule

// File: tb/method_router_test.sv
module method_router_test;
  localparam int DEPTH = 8, MW = 16, NSUB = 8, EW = 2, DW = 32, SW = 3, RW = 16;
  localparam int FW = EW + SW + MW + DW;

  logic clk = 0, rst_n = 0;
  logic cmd_push = 0;
  logic [MW-1:0] cmd_method = 0;
  logic [SW-1:0] cmd_subch = 0;
  logic [DW-1:0] cmd_param = 0;
  logic cmd_full;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [RW-1:0] reg_wdata = 0, reg_rdata;
  logic lk_valid, lk_ready, lk_resp_valid;
  logic [DW-1:0] lk_handle;
  logic [EW-1:0] lk_resp_engine;
  logic eng_valid, eng_ready;
  logic [EW-1:0] eng_code;
  logic [SW-1:0] eng_subch;
  logic [MW-1:0] eng_method;
  logic [DW-1:0] eng_param;

  method_router uut (.*);

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0, fwd_seen = 0;
  logic [FW-1:0] fwd_exp[$];
  logic [DW-1:0] lk_exp[$];
  logic [NSUB*EW-1:0] mbind = 0;
  logic [EW-1:0] mlast = 0;
  logic lk_busy = 0, eng_stall = 0;

  function automatic logic [EW-1:0] eng_of(logic [DW-1:0] h);
    return h[1:0] ^ h[9:8];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [MW-1:0] m, logic [SW-1:0] s, logic [DW-1:0] p);
    @(posedge clk); #2;
    if (!cmd_full) begin
      if (m == 0) begin
        lk_exp.push_back(p);
        mbind[s*EW +: EW] = eng_of(p);
        mlast = eng_of(p);
      end else if (m >= 16'h100)
        fwd_exp.push_back({mbind[s*EW +: EW], s, m, p});
    end
    cmd_push = 1; cmd_method = m; cmd_subch = s; cmd_param = p;
    @(posedge clk); #2;
    cmd_push = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [RW-1:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [RW-1:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic drain();
    logic [RW-1:0] st;
    for (int k = 0; k < 2000; k++) begin
      rd(2'd2, st);
      if (st[0] && fwd_exp.size() == 0 && lk_exp.size() == 0 && !lk_busy && !eng_valid) break;
    end
    repeat (3) @(posedge clk);
  endtask

  // lookup responder
  initial begin
    logic [DW-1:0] hnd;
    lk_ready = 0; lk_resp_valid = 0; lk_resp_engine = 0;
    forever begin
      @(posedge clk); #2;
      lk_ready = 0; lk_resp_valid = 0;
      if (lk_valid && ($urandom % 3 == 0)) begin
        lk_ready = 1; lk_busy = 1; hnd = lk_handle;
        if (lk_exp.size() == 0) chk("R2 unexpected lookup", 64'(hnd), 64'hdead);
        else chk("R2 lookup handle", 64'(hnd), 64'(lk_exp.pop_front()));
        @(posedge clk); #2;
        lk_ready = 0;
        for (int k = 0; k < int'($urandom % 4); k++) begin @(posedge clk); #2; end
        lk_resp_valid = 1; lk_resp_engine = eng_of(hnd);
        @(posedge clk); #2;
        lk_resp_valid = 0; lk_busy = 0;
      end
    end
  end

  // engine ready driver
  initial begin
    eng_ready = 0;
    forever begin
      @(posedge clk); #2;
      eng_ready = !eng_stall && ($urandom % 4 != 0);
    end
  end

  // engine monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_valid && eng_ready) begin
        fwd_seen++;
        if (fwd_exp.size() == 0)
          chk("R6 unexpected forward", 64'(eng_method), 64'hffff);
        else
          chk("R4 forwarded entry", 64'({eng_code, eng_subch, eng_method, eng_param}),
              64'(fwd_exp.pop_front()));
      end
    end
  end

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [RW-1:0] d;
    int seen0;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 full", 64'(cmd_full), 0);
    chk("R10 lk_valid", 64'(lk_valid), 0);
    chk("R10 eng_valid", 64'(eng_valid), 0);
    rd(2'd0, d); chk("R10 pull off", 64'(d), 0);
    rd(2'd1, d); chk("R10 bindings", 64'(d), 0);
    rd(2'd2, d); chk("R10 R8 status empty", 64'(d), 1);

    // R7 packed bindings
    wr(2'd1, 16'hE4B1); mbind = 16'hE4B1;
    rd(2'd1, d); chk("R7 readback", 64'(d), 64'hE4B1);
    rd(2'd3, d); chk("R8 unused address", 64'(d), 0);

    // R1 halt while pull disabled
    seen0 = fwd_seen;
    push(16'h100, 3'd1, 32'h11); push(16'h104, 3'd2, 32'h22); push(16'h108, 3'd3, 32'h33);
    repeat (10) @(posedge clk);
    rd(2'd2, d); chk("R1 held while disabled", 64'(d[0]), 0);
    chk("R1 nothing forwarded", 64'(fwd_seen - seen0), 0);
    wr(2'd0, 16'h1);
    drain();
    chk("R1 resumed", 64'(fwd_seen - seen0), 3);

    // R6 ignored methods
    seen0 = fwd_seen;
    push(16'h0FC, 3'd0, 32'h5); push(16'h004, 3'd7, 32'h6);
    drain();
    rd(2'd2, d); chk("R6 consumed", 64'(d[0]), 1);
    chk("R6 no forward", 64'(fwd_seen - seen0), 0);

    // R4 R7 slot positions
    wr(2'd1, 16'h1B6C); mbind = 16'h1B6C;
    for (int i = 0; i < NSUB; i++) push(16'h200 + 16'(i * 4), 3'(i), 32'(i));
    drain();

    // R9 overflow
    wr(2'd0, 16'h0);
    seen0 = fwd_seen;
    for (int i = 0; i < DEPTH + 2; i++) push(16'h300, 3'd5, 32'h100 + 32'(i));
    chk("R9 full", 64'(cmd_full), 1);
    wr(2'd0, 16'h1);
    drain();
    chk("R9 drops surplus", 64'(fwd_seen - seen0), DEPTH);

    // R5 stall
    eng_stall = 1;
    push(16'h400, 3'd6, 32'hCAFE);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5 held valid", 64'(eng_valid), 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 held fields", 64'({eng_subch, eng_method, eng_param}), 64'({3'd6, 16'h400, 32'hCAFE}));
    eng_stall = 0;
    drain();

    // R2 R3 random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 20);
      if (r < 5) push(16'h0, 3'($urandom), $urandom);
      else if (r < 8) push(16'(($urandom % 63 + 1) * 4), 3'($urandom), $urandom);
      else push(16'h100 + 16'(($urandom % 1984) * 4), 3'($urandom), $urandom);
      if ($urandom % 40 == 0) begin
        wr(2'd0, 16'h0);
        repeat ($urandom % 6) @(posedge clk);
        wr(2'd0, 16'h1);
      end
    end
    drain();
    rd(2'd1, d); chk("R3 binding table", 64'(d), 64'(mbind));
    rd(2'd2, d); chk("R8 R3 last engine", 64'(d[9:8]), 64'(mlast));
    chk("R4 all forwarded", 64'(fwd_exp.size()), 0);
    chk("R2 all looked up", 64'(lk_exp.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule